// File: doc/BRIEF.md
# Three-Phase Commutation Output Controller

This block produces the six gate-drive outputs of a three-phase brushless motor stage: one high-side (positive) and one low-side (negative) output per phase U, V and W. Each cycle it looks up the current three-bit rotor position pattern in a 120-degree commutation table. The result selects which high-side output and which low-side output are active. An active output drives either a steady level or the PWM signal from an external timer, chosen separately for each side. A polarity bit can invert all six outputs.

The position pattern comes from one of two sources. The first is three external Hall-type sensor inputs, which are synchronised and can also pass through a majority-free three-sample noise filter with a selectable sample rate. The second is three bits written by software. The pattern in use can be sampled on every clock or only when the timer marks a PWM period boundary. A single 32-bit control register holds all settings and reads back the captured pattern. An output-disable request from one selectable group among four can clear the output enable, which releases all six outputs to high impedance.

Top module: `commOutCtrl`

## Requirements
- R1: Register bit 7 selects the phase source: 0 takes the synchronised (optionally filtered) external inputs hallIn, 1 takes the software bits at register bits 2:0 (bit 0 = U, bit 1 = V, bit 2 = W).
- R2: While bit 7 is 0, the software bits in 2:0 have no effect on the captured pattern or on the outputs.
- R3: Register bits 5:3 are read-only and return the captured pattern in use, in U, V, W order from bit 3.
- R4: While the output-enable bit (bit 6) is 0, gateOe is 0 and all six outputs are high impedance. They are driven only while bit 6 is 1.
- R5: With bits 10:8 at 0, the table maps the pattern {U,V,W} as follows: 101 gives U+ and V-; 100 gives U+ and W-; 110 gives V+ and W-; 010 gives V+ and U-; 011 gives W+ and U-; 001 gives W+ and V-. Patterns 000 and 111 turn all outputs off. gateLvl bits 2:0 are U+, V+, W+ and bits 5:3 are U-, V-, W-. An active output is 1 and an inactive one is 0.
- R6: Bit 8 (positive side) and bit 9 (negative side) choose what an active output of that side drives: 0 gives a steady 1 and 1 gives pwmIn. An inactive output stays 0.
- R7: Bit 10 set to 1 inverts all six output levels, making the outputs active-low.
- R8: With bit 11 at 0, the pattern is captured on every clock. With bit 11 at 1, it is captured only on a clock where pwmPeriodPulse is 1 and holds otherwise.
- R9: When bit 14 is 1 and the disableReq line chosen by bits 13:12 is 1 at a clock edge, bit 6 is cleared at that edge. This takes priority over a write in the same cycle.
- R10: When bit 14 is 0, or when the requesting line is not the one chosen, disable requests leave bit 6 unchanged.
- R11: With bit 15 at 1 and bits 17:16 at 0, each external input is sampled every clock. A new level reaches the pattern only after three consecutive samples agree, so a 2-cycle pulse is rejected.
- R12: Bits 17:16 set the filter sample period to 1, 4, 16 or 64 clocks (codes 0 to 3). At code 1 an 8-cycle pulse is rejected, and at code 3 a 100-cycle pulse is rejected. Longer steady levels pass.
- R13: After reset the register reads 0, gateOe is 0, the external source is selected and the filter is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Control register write strobe |
| regWdata | input | 32 | Control register write data |
| regRdata | output | 32 | Control register read data including captured pattern |
| hallIn | input | 3 | External position sensor inputs (bit 0 U, 1 V, 2 W) |
| pwmIn | input | 1 | PWM waveform from the timer |
| pwmPeriodPulse | input | 1 | One-cycle marker of a PWM period boundary |
| disableReq | input | 4 | Output-disable requests from groups A to D |
| gateLvl | output | 6 | Gate levels: 2:0 high side U,V,W; 5:3 low side U,V,W |
| gateOe | output | 1 | Gate drive enable; 0 means high impedance |

## Verification
The commutation table is swept through all eight software patterns under every combination of the high-side mode, low-side mode and polarity bits, with pwmIn at both levels. This separates a wrong table entry from a side that has swapped its level and PWM choice. The external path is swept with software bits set to the complement of the sensor pattern, so any leak of the software source into the external mode shows up. Filter pulses are sized just under the acceptance window at three sample rates. A wrong divider therefore either passes a pulse that must be rejected or fails to settle. Disable requests are sent on a non-selected line, on the selected line with the function off, and on the selected line with it on.

// File: rtl/commPkg.sv
package commPkg;
  localparam int PHASES = 3;
  localparam int REG_W = 32;
  localparam int GROUPS = 4;
  localparam int GRP_W = $clog2(GROUPS);
  localparam int FDIV_W = 2;
  localparam int SYNC_STAGES = 2;

  localparam int B_SW = 0;
  localparam int B_MON = 3;
  localparam int B_OE = 6;
  localparam int B_SRC = 7;
  localparam int B_POSPWM = 8;
  localparam int B_NEGPWM = 9;
  localparam int B_INV = 10;
  localparam int B_ALIGN = 11;
  localparam int B_GRP = 12;
  localparam int B_GFN = 14;
  localparam int B_FEN = 15;
  localparam int B_FDIV = 16;

  typedef struct packed {
    logic [PHASES-1:0] swPhase;
    logic              srcSw;
    logic              posPwm;
    logic              negPwm;
    logic              invert;
    logic              alignPwm;
    logic              filtEn;
    logic [FDIV_W-1:0] filtDiv;
  } commCfgT;
endpackage

// File: rtl/phaseFilter.sv
module phaseFilter (
  input  logic clk,
  input  logic rstN,
  input  logic tick,
  input  logic din,
  output logic dout
);
  logic hist0, hist1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hist0 <= 1'b0;
      hist1 <= 1'b0;
      dout  <= 1'b0;
    end else if (tick) begin
      hist1 <= hist0;
      hist0 <= din;
      if (din == hist0 && hist0 == hist1) dout <= din;
    end
  end
endmodule

// File: rtl/commCtrl.sv
module commCtrl
  import commPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [REG_W-1:0]  regWdata,
  input  logic [PHASES-1:0] phaseMon,
  input  logic [GROUPS-1:0] disableReq,
  output commCfgT           cfg,
  output logic              outEn,
  output logic [REG_W-1:0]  regRdata
);
  logic [GRP_W-1:0] grpSel;
  logic             grpFn;
  logic             groupHit;

  assign groupHit = grpFn & disableReq[grpSel];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg    <= '0;
      outEn  <= 1'b0;
      grpSel <= '0;
      grpFn  <= 1'b0;
    end else begin
      if (regWe) begin
        cfg.swPhase  <= regWdata[B_SW +: PHASES];
        cfg.srcSw    <= regWdata[B_SRC];
        cfg.posPwm   <= regWdata[B_POSPWM];
        cfg.negPwm   <= regWdata[B_NEGPWM];
        cfg.invert   <= regWdata[B_INV];
        cfg.alignPwm <= regWdata[B_ALIGN];
        cfg.filtEn   <= regWdata[B_FEN];
        cfg.filtDiv  <= regWdata[B_FDIV +: FDIV_W];
        grpSel       <= regWdata[B_GRP +: GRP_W];
        grpFn        <= regWdata[B_GFN];
        outEn        <= regWdata[B_OE];
      end
      if (groupHit) outEn <= 1'b0;
    end
  end

  always_comb begin
    regRdata = '0;
    regRdata[B_SW +: PHASES]  = cfg.swPhase;
    regRdata[B_MON +: PHASES] = phaseMon;
    regRdata[B_OE]            = outEn;
    regRdata[B_SRC]           = cfg.srcSw;
    regRdata[B_POSPWM]        = cfg.posPwm;
    regRdata[B_NEGPWM]        = cfg.negPwm;
    regRdata[B_INV]           = cfg.invert;
    regRdata[B_ALIGN]         = cfg.alignPwm;
    regRdata[B_GRP +: GRP_W]  = grpSel;
    regRdata[B_GFN]           = grpFn;
    regRdata[B_FEN]           = cfg.filtEn;
    regRdata[B_FDIV +: FDIV_W] = cfg.filtDiv;
  end
endmodule

// File: rtl/commDatapath.sv
module commDatapath
  import commPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  commCfgT             cfg,
  input  logic                outEn,
  input  logic [PHASES-1:0]   hallIn,
  input  logic                pwmIn,
  input  logic                pwmPeriodPulse,
  output logic [PHASES-1:0]   phaseMon,
  output logic [2*PHASES-1:0] gateLvl,
  output logic                gateOe
);
  localparam int PRE_W = 2 * ((1 << FDIV_W) - 1);
  localparam logic [PRE_W-1:0] PRE_ONE = {{(PRE_W-1){1'b0}}, 1'b1};
  localparam logic [PRE_W:0]   LIM_ONE = {{PRE_W{1'b0}}, 1'b1};

  logic [PHASES-1:0] syncQ [SYNC_STAGES];
  logic [PHASES-1:0] filtQ, extPh, srcPh, capPh;
  logic [PRE_W-1:0]  preCnt, preLimit;
  logic [PRE_W:0]    limWide, limMinus;
  logic              tick;
  logic [PHASES-1:0] posOn, negOn;
  logic              posDrive, negDrive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) syncQ[i] <= '0;
    end else begin
      syncQ[0] <= hallIn;
      for (int i = 1; i < SYNC_STAGES; i++) syncQ[i] <= syncQ[i-1];
    end
  end

  always_comb begin
    limWide  = LIM_ONE << {cfg.filtDiv, 1'b0};
    limMinus = limWide - LIM_ONE;
    preLimit = limMinus[PRE_W-1:0];
  end

  assign tick = (preCnt == preLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preCnt <= '0;
    else if (tick) preCnt <= '0;
    else preCnt <= preCnt + PRE_ONE;
  end

  for (genvar k = 0; k < PHASES; k++) begin : gFilt
    phaseFilter uFilt (
      .clk  (clk),
      .rstN (rstN),
      .tick (tick),
      .din  (syncQ[SYNC_STAGES-1][k]),
      .dout (filtQ[k])
    );
  end

  assign extPh = cfg.filtEn ? filtQ : syncQ[SYNC_STAGES-1];
  assign srcPh = cfg.srcSw ? cfg.swPhase : extPh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) capPh <= '0;
    else if (!cfg.alignPwm || pwmPeriodPulse) capPh <= srcPh;
  end

  assign phaseMon = capPh;

  always_comb begin
    posOn = '0;
    negOn = '0;
    case ({capPh[0], capPh[1], capPh[2]})
      3'b101: begin posOn = 3'b001; negOn = 3'b010; end
      3'b100: begin posOn = 3'b001; negOn = 3'b100; end
      3'b110: begin posOn = 3'b010; negOn = 3'b100; end
      3'b010: begin posOn = 3'b010; negOn = 3'b001; end
      3'b011: begin posOn = 3'b100; negOn = 3'b001; end
      3'b001: begin posOn = 3'b100; negOn = 3'b010; end
      default: begin posOn = '0; negOn = '0; end
    endcase
  end

  assign posDrive = cfg.posPwm ? pwmIn : 1'b1;
  assign negDrive = cfg.negPwm ? pwmIn : 1'b1;

  for (genvar k = 0; k < PHASES; k++) begin : gOut
    assign gateLvl[k]          = (posOn[k] & posDrive) ^ cfg.invert;
    assign gateLvl[PHASES + k] = (negOn[k] & negDrive) ^ cfg.invert;
  end

  assign gateOe = outEn;
endmodule

// File: rtl/commOutCtrl.sv
module commOutCtrl
  import commPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWe,
  input  logic [REG_W-1:0]    regWdata,
  output logic [REG_W-1:0]    regRdata,
  input  logic [PHASES-1:0]   hallIn,
  input  logic                pwmIn,
  input  logic                pwmPeriodPulse,
  input  logic [GROUPS-1:0]   disableReq,
  output logic [2*PHASES-1:0] gateLvl,
  output logic                gateOe
);
  commCfgT           cfg;
  logic              outEn;
  logic [PHASES-1:0] phaseMon;

  commCtrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .regWe      (regWe),
    .regWdata   (regWdata),
    .phaseMon   (phaseMon),
    .disableReq (disableReq),
    .cfg        (cfg),
    .outEn      (outEn),
    .regRdata   (regRdata)
  );

  commDatapath uPath (
    .clk            (clk),
    .rstN           (rstN),
    .cfg            (cfg),
    .outEn          (outEn),
    .hallIn         (hallIn),
    .pwmIn          (pwmIn),
    .pwmPeriodPulse (pwmPeriodPulse),
    .phaseMon       (phaseMon),
    .gateLvl        (gateLvl),
    .gateOe         (gateOe)
  );
endmodule

// File: rtl/commOutCtrlChk.sv
module commOutCtrlChk
  import commPkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                regWe,
  input logic [REG_W-1:0]    regRdata,
  input logic                pwmPeriodPulse,
  input logic [GROUPS-1:0]   disableReq,
  input logic [2*PHASES-1:0] gateLvl,
  input logic                gateOe
);
  // R9: a selected request with the function on releases the gates next cycle
  a_r9_group_clears: assert property (@(posedge clk) disable iff (!rstN)
    (regRdata[B_GFN] && disableReq[regRdata[B_GRP +: GRP_W]]) |=> !gateOe);

  // R10: with the function off and no write, the enable holds
  a_r10_no_clear: assert property (@(posedge clk) disable iff (!rstN)
    (!regWe && !regRdata[B_GFN] && gateOe) |=> gateOe);

  // R5: at most one high side and one low side, never on the same phase
  a_r5_single_pair: assert property (@(posedge clk) disable iff (!rstN)
    (gateOe && regRdata[B_INV:B_POSPWM] == 3'b000) |->
      ($countones(gateLvl[PHASES-1:0]) <= 1 &&
       $countones(gateLvl[2*PHASES-1:PHASES]) <= 1 &&
       (gateLvl[PHASES-1:0] & gateLvl[2*PHASES-1:PHASES]) == '0));

  // R8: between period boundaries the captured pattern holds
  a_r8_hold_between_boundaries: assert property (@(posedge clk) disable iff (!rstN)
    (regRdata[B_ALIGN] && !pwmPeriodPulse && !regWe) |=>
      $stable(regRdata[B_MON +: PHASES]));

  // R1: software source with per-clock capture follows the software bits
  a_r1_sw_follow: assert property (@(posedge clk) disable iff (!rstN)
    (regRdata[B_SRC] && !regRdata[B_ALIGN] && !regWe) |=>
      regRdata[B_MON +: PHASES] == $past(regRdata[B_SW +: PHASES]));
endmodule

bind commOutCtrl commOutCtrlChk u_chk (
  .clk            (clk),
  .rstN           (rstN),
  .regWe          (regWe),
  .regRdata       (regRdata),
  .pwmPeriodPulse (pwmPeriodPulse),
  .disableReq     (disableReq),
  .gateLvl        (gateLvl),
  .gateOe         (gateOe)
);

// File: tb/sim_commOutCtrl.sv
`timescale 1ns/1ps
module sim_commOutCtrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [2:0]  hallIn = '0;
  logic        pwmIn = 1'b0;
  logic        pwmPeriodPulse = 1'b0;
  logic [3:0]  disableReq = '0;
  logic [5:0]  gateLvl;
  logic        gateOe;
  int          checks = 0;
  int          failures = 0;
  bit          finished = 1'b0;

  always #4 clk = ~clk;

  commOutCtrl u0 (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regWdata(regWdata), .regRdata(regRdata),
    .hallIn(hallIn), .pwmIn(pwmIn), .pwmPeriodPulse(pwmPeriodPulse),
    .disableReq(disableReq), .gateLvl(gateLvl), .gateOe(gateOe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] cw(input logic [2:0] sw, input logic oe, input logic src,
                                     input logic pp, input logic np, input logic inv,
                                     input logic al, input logic [1:0] grp, input logic fn,
                                     input logic fe, input logic [1:0] fd);
    logic [31:0] v;
    v = '0;
    v[2:0] = sw; v[6] = oe; v[7] = src; v[8] = pp; v[9] = np; v[10] = inv;
    v[11] = al; v[13:12] = grp; v[14] = fn; v[15] = fe; v[17:16] = fd;
    return v;
  endfunction

  function automatic logic [5:0] expGate(input logic [2:0] p, input logic pp, input logic np,
                                         input logic inv, input logic pwm);
    logic [2:0] po, ne;
    logic [5:0] g;
    logic pl, nl;
    po = '0; ne = '0;
    case ({p[0], p[1], p[2]})
      3'b101: begin po = 3'b001; ne = 3'b010; end
      3'b100: begin po = 3'b001; ne = 3'b100; end
      3'b110: begin po = 3'b010; ne = 3'b100; end
      3'b010: begin po = 3'b010; ne = 3'b001; end
      3'b011: begin po = 3'b100; ne = 3'b001; end
      3'b001: begin po = 3'b100; ne = 3'b010; end
      default: begin po = '0; ne = '0; end
    endcase
    pl = pp ? pwm : 1'b1;
    nl = np ? pwm : 1'b1;
    for (int k = 0; k < 3; k++) begin
      g[k]     = (po[k] & pl) ^ inv;
      g[3 + k] = (ne[k] & nl) ^ inv;
    end
    return g;
  endfunction

  task automatic wr(input logic [31:0] v);
    @(negedge clk); regWe = 1'b1; regWdata = v;
    @(negedge clk); regWe = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic watch(input int n, input logic [2:0] expv, inout int bad);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (regRdata[5:3] !== expv) bad++;
    end
  endtask

  task automatic pulseBoundary();
    pwmPeriodPulse = 1'b1;
    @(negedge clk);
    pwmPeriodPulse = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int bad;
    idle(5);
    rstN = 1'b1;
    idle(1);
    // R13 reset state
    chk("R13 register after reset", regRdata, 32'h0);
    chk("R13 gateOe after reset", {31'b0, gateOe}, 32'h0);

    // R3 R5 R6 R7: software source sweep over patterns and drive modes
    for (int p = 0; p < 8; p++) begin
      for (int m = 0; m < 8; m++) begin
        logic [2:0] pv, mv;
        string tag;
        pv = 3'(p);
        mv = 3'(m);
        tag = (m == 0) ? "R5 table" : (mv[2] ? "R7 invert" : "R6 side mode");
        wr(cw(pv, 1'b1, 1'b1, mv[0], mv[1], mv[2], 1'b0, 2'd0, 1'b0, 1'b0, 2'd0));
        idle(1);
        chk("R3 monitor shows software pattern", {29'b0, regRdata[5:3]}, {29'b0, pv});
        for (int w = 0; w < 2; w++) begin
          pwmIn = w[0];
          #1;
          chk(tag, {26'b0, gateLvl}, {26'b0, expGate(pv, mv[0], mv[1], mv[2], w[0])});
        end
        chk("R4 gateOe driven when enabled", {31'b0, gateOe}, 32'h1);
      end
    end
    pwmIn = 1'b0;

    // R4 enable low releases outputs
    wr(cw(3'b101, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0));
    idle(1);
    chk("R4 high impedance when disabled", {31'b0, gateOe}, 32'h0);

    // R1 R2 external source sweep with complementary software bits
    for (int p = 0; p < 8; p++) begin
      logic [2:0] pv;
      pv = 3'(p);
      hallIn = pv;
      wr(cw(~pv, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0));
      idle(3);
      chk("R2 software bits ignored on external source", {29'b0, regRdata[5:3]}, {29'b0, pv});
      chk("R1 gates follow external pattern", {26'b0, gateLvl},
          {26'b0, expGate(pv, 1'b0, 1'b0, 1'b0, 1'b0)});
      wr(cw(~pv, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0));
      idle(1);
      chk("R1 switch to software source", {29'b0, regRdata[5:3]}, {29'b0, ~pv});
    end

    // R8 capture aligned to PWM boundary
    hallIn = 3'b001;
    wr(cw(3'b000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 2'd0));
    idle(4);
    pulseBoundary();
    chk("R8 captured at boundary", {29'b0, regRdata[5:3]}, 32'h1);
    hallIn = 3'b100;
    idle(6);
    chk("R8 held between boundaries", {29'b0, regRdata[5:3]}, 32'h1);
    pulseBoundary();
    chk("R8 updated at next boundary", {29'b0, regRdata[5:3]}, 32'h4);

    // R9 R10 group disable
    wr(cw(3'b101, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 1'b1, 1'b0, 2'd0));
    idle(1);
    disableReq = 4'b0010;
    idle(1);
    disableReq = 4'b0000;
    chk("R10 non-selected group ignored", {31'b0, gateOe}, 32'h1);
    disableReq = 4'b0100;
    idle(1);
    disableReq = 4'b0000;
    chk("R9 selected group clears enable", {31'b0, gateOe}, 32'h0);
    chk("R9 enable bit reads zero", {31'b0, regRdata[6]}, 32'h0);
    wr(cw(3'b101, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 1'b0, 1'b0, 2'd0));
    disableReq = 4'b0100;
    idle(2);
    disableReq = 4'b0000;
    chk("R10 function off ignores request", {31'b0, gateOe}, 32'h1);

    // R11 filter at full rate
    hallIn = 3'b000;
    wr(cw(3'b000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 2'd0));
    idle(20);
    bad = 0;
    hallIn = 3'b001;
    watch(2, 3'b000, bad);
    hallIn = 3'b000;
    watch(20, 3'b000, bad);
    chk("R11 two-cycle pulse rejected", bad, 0);
    hallIn = 3'b001;
    idle(12);
    chk("R11 steady level passes", {29'b0, regRdata[5:3]}, 32'h1);

    // R12 filter at divide-by-4
    wr(cw(3'b000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 2'd1));
    idle(40);
    bad = 0;
    hallIn = 3'b000;
    watch(8, 3'b001, bad);
    hallIn = 3'b001;
    watch(40, 3'b001, bad);
    chk("R12 divide-by-4 rejects 8-cycle pulse", bad, 0);
    hallIn = 3'b000;
    idle(40);
    chk("R12 divide-by-4 steady level passes", {29'b0, regRdata[5:3]}, 32'h0);

    // R12 filter at divide-by-64
    wr(cw(3'b000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 2'd3));
    idle(200);
    bad = 0;
    hallIn = 3'b010;
    watch(100, 3'b000, bad);
    hallIn = 3'b000;
    watch(200, 3'b000, bad);
    chk("R12 divide-by-64 rejects 100-cycle pulse", bad, 0);
    hallIn = 3'b010;
    idle(400);
    chk("R12 divide-by-64 steady level passes", {29'b0, regRdata[5:3]}, 32'h2);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule